// File: doc/BRIEF.md
# Row-Staging Write Sequencer with One-Way Lower-Half Lock

This block sits behind a serial-bus slave engine in a small byte-addressed non-volatile store. The engine decodes the bus. It hands this block four things: the opening of a write transaction (to the array or to the protection register), the received byte address, each received data byte, and a strobe for a STOP that lands in the slot right after an acknowledge bit. The block collects the data bytes into one 16-byte row buffer. It decides for each byte whether the engine should acknowledge it, and it copies the accepted bytes into the array only when the correctly placed STOP arrives.

A commit starts a self-timed write phase of a fixed number of clock cycles. During that phase the staged bytes go out through a RAM write port, one byte per cycle, and every request from the engine is ignored. A permanent lock bit covers the lower half of the address space. It is set by committing a write to the protection register, and only reset clears it. A hardware write-control input blocks every write while it is high, and that includes setting the lock.

Top module: `pgw_seq`

## Requirements
- R1: After reset, busy_o and mem_we_o are low, ack_ok_o is low while no transaction is open, and the lock is clear.
- R2: While an array transaction is open, ack_ok_o is high for a data byte when wc_i is low and the byte's row is not protected. A row is protected when the lock is set and the address MSB is 0 (00h–7Fh).
- R3: Bytes are staged into the row given by address bits 7..4 of the received address. Only the low 4 bits advance after each data byte, whether or not that byte was acknowledged.
- R4: When more than 16 bytes are sent, the offset wraps within the row, and a later byte replaces the earlier byte at the same offset.
- R5: The array changes only after stop_ack_i while a transaction is open. A new txn_start_i without that strobe discards the staged bytes.
- R6: A commit writes exactly the offsets that received an acknowledged byte, each with its last value. All other locations keep their contents.
- R7: busy_o rises in the cycle after the commit strobe and stays high for exactly WR_CYCLES cycles. Every write happens while busy_o is high. While busy, txn_start_i is ignored and ack_ok_o stays low.
- R8: While wc_i is high, no data byte is acknowledged, nothing is staged, and a protection-register transaction does not set the lock.
- R9: A committed protection-register transaction (txn_prot_i=1) with at least one acknowledged data byte sets the lock. After that, bytes at 00h–7Fh are refused and left unwritten, and 80h–FFh stay writable.
- R10: Once set, the lock stays set through any later traffic. Only rst_ni clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_start_i | input | 1 | Pulse: write transaction opened by the bus engine |
| txn_prot_i | input | 1 | With txn_start_i: 1 targets the protection register, 0 the array |
| addr_vld_i | input | 1 | Pulse: byte address received |
| addr_i | input | ADDR_W | Received byte address |
| data_vld_i | input | 1 | Pulse: data byte received |
| data_i | input | 8 | Received data byte |
| stop_ack_i | input | 1 | Pulse: STOP placed directly after an acknowledge bit |
| wc_i | input | 1 | Write control; high blocks all writes |
| ack_ok_o | output | 1 | The data byte presented now is to be acknowledged |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | ADDR_W | RAM write address |
| mem_wdata_o | output | 8 | RAM write data |

## Verification
The assertions rely on the engine issuing at most one of txn_start_i, addr_vld_i, data_vld_i and stop_ack_i per cycle. They also rely on the engine sending the address byte before any data byte and holding wc_i steady for the length of a transaction. The bench drives each strobe from its own clock cycle inside a task and changes wc_i only between transactions. The random lengths from 1 to 20 bytes and the random start offsets exercise row wrap and partial rows without breaking that ordering.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/pgw_stage.sv
module pgw_stage import pgw_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int OFS_W  = 4,
  localparam int ROWB  = 1 << OFS_W,
  localparam int ROW_W = ADDR_W - OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic             data_vld_i,
  input  logic             keep_i,
  input  byte_t            data_i,
  input  logic [OFS_W-1:0] rd_ofs_i,
  output logic [ROW_W-1:0] row_o,
  output logic [ROWB-1:0]  mask_o,
  output byte_t            rd_data_o
);
  logic [ROW_W-1:0] row_q;
  logic [OFS_W-1:0] ptr_q;
  logic [ROWB-1:0]  mask_q;
  byte_t            buf_q [ROWB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      ptr_q  <= '0;
      mask_q <= '0;
    end else if (clr_i) begin
      mask_q <= '0;
    end else if (addr_vld_i) begin
      row_q <= addr_i[ADDR_W-1:OFS_W];
      ptr_q <= addr_i[OFS_W-1:0];
    end else if (data_vld_i) begin
      ptr_q <= ptr_q + 1'b1;  // low bits only: wraps inside the row
      if (keep_i) mask_q[ptr_q] <= 1'b1;
    end
  end

  for (genvar g = 0; g < ROWB; g++) begin : g_buf
    always_ff @(posedge clk_i) begin
      if (data_vld_i && keep_i && !clr_i && !addr_vld_i && ptr_q == OFS_W'(g))
        buf_q[g] <= data_i;
    end
  end

  assign row_o     = row_q;
  assign mask_o    = mask_q;
  assign rd_data_o = buf_q[rd_ofs_i];

  // refused byte leaves the mask untouched
  assert_refused_not_staged_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_vld_i && !keep_i && !clr_i && !addr_vld_i) |=> $stable(mask_q));
endmodule

// File: rtl/pgw_guard.sv
module pgw_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic open_i,
  input  logic busy_i,
  input  logic prot_i,
  input  logic wc_i,
  input  logic row_msb_i,
  input  logic data_vld_i,
  input  logic commit_i,
  output logic ack_ok_o,
  output logic locked_o
);
  logic locked_q, pend_q;

  assign ack_ok_o = open_i && !busy_i && !wc_i && (prot_i || !(locked_q && !row_msb_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (clr_i) pend_q <= 1'b0;
      else if (data_vld_i && ack_ok_o && prot_i) pend_q <= 1'b1;
      if (commit_i && prot_i && pend_q) locked_q <= 1'b1;
    end
  end

  assign locked_o = locked_q;

  assert_lock_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);
  assert_wc_no_pend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_vld_i && wc_i && !clr_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int WR_CYCLES = 40,
  localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (commit_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(WR_CYCLES - 1)) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  assert_busy_from_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(commit_i));
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq import pgw_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int OFS_W     = 4,
  parameter int WR_CYCLES = 40,
  localparam int ROWB  = 1 << OFS_W,
  localparam int ROW_W = ADDR_W - OFS_W,
  localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_start_i,
  input  logic              txn_prot_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_vld_i,
  input  logic [7:0]        data_i,
  input  logic              stop_ack_i,
  input  logic              wc_i,
  output logic              ack_ok_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  logic             open_q, prot_q, busy, locked, ack_ok;
  logic             start_ok, commit, addr_ok, data_ok;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] row;
  logic [ROWB-1:0]  mask;
  logic [OFS_W-1:0] rd_ofs;
  byte_t            rd_data;

  initial begin
    assert (WR_CYCLES >= ROWB) else $error("WR_CYCLES below row size");
    assert (ADDR_W > OFS_W)    else $error("ADDR_W too small");
  end

  assign start_ok = txn_start_i && !busy;
  assign commit   = stop_ack_i && open_q && !busy;
  assign addr_ok  = addr_vld_i && open_q && !busy;
  assign data_ok  = data_vld_i && open_q && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      prot_q <= 1'b0;
    end else if (start_ok) begin
      open_q <= 1'b1;
      prot_q <= txn_prot_i;
    end else if (commit) begin
      open_q <= 1'b0;
    end
  end

  pgw_stage #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_stage (
    .clk_i, .rst_ni,
    .clr_i(start_ok), .addr_vld_i(addr_ok), .addr_i,
    .data_vld_i(data_ok), .keep_i(ack_ok && !prot_q), .data_i,
    .rd_ofs_i(rd_ofs), .row_o(row), .mask_o(mask), .rd_data_o(rd_data)
  );

  pgw_guard u_guard (
    .clk_i, .rst_ni, .clr_i(start_ok), .open_i(open_q), .busy_i(busy),
    .prot_i(prot_q), .wc_i, .row_msb_i(row[ROW_W-1]), .data_vld_i(data_ok),
    .commit_i(commit), .ack_ok_o(ack_ok), .locked_o(locked)
  );

  pgw_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni, .commit_i(commit), .busy_o(busy), .cnt_o(cnt)
  );

  // drain one row slot per busy cycle
  assign rd_ofs      = cnt[OFS_W-1:0];
  assign mem_we_o    = busy && (cnt < CNT_W'(ROWB)) && mask[rd_ofs];
  assign mem_addr_o  = {row, rd_ofs};
  assign mem_wdata_o = rd_data;
  assign ack_ok_o    = ack_ok;
  assign busy_o      = busy;

  assert_we_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  assert_lock_region_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && locked) |-> mem_addr_o[ADDR_W-1]);
  assert_no_ack_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ack_ok_o);
endmodule

// File: tb/pgw_seq_bench.sv
module pgw_seq_bench;
  localparam int WR = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_start = 0, txn_prot = 0, addr_vld = 0, data_vld = 0, stop_ack = 0, wc = 0;
  logic [7:0] addr = 0, data = 0;
  logic ack_ok, busy, mem_we;
  logic [7:0] mem_addr, mem_wdata;

  int checks = 0, errors = 0;
  bit lock_m = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] dut_mem [256];
  logic [7:0] tx_data [32];

  always #10 clk = ~clk;

  pgw_seq #(.ADDR_W(8), .OFS_W(4), .WR_CYCLES(WR)) u_pgw_seq (
    .clk_i(clk), .rst_ni(rst_n), .txn_start_i(txn_start), .txn_prot_i(txn_prot),
    .addr_vld_i(addr_vld), .addr_i(addr), .data_vld_i(data_vld), .data_i(data),
    .stop_ack_i(stop_ack), .wc_i(wc), .ack_ok_o(ack_ok), .busy_o(busy),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  always @(negedge clk) if (mem_we) dut_mem[mem_addr] = mem_wdata;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ack(input bit prot, input bit w, input bit lk, input int row);
    return !w && (prot || !(lk && row < 8));
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic mem_cmp(input string req);
    int mism = 0;
    for (int i = 0; i < 256; i++) if (dut_mem[i] !== ref_mem[i]) mism++;
    chk(mism == 0, req, "memory mismatches", mism, 0);
  endtask

  task automatic run_txn(input bit prot, input int start, input int n, input bit w,
                         input bit commit, input bit poke, input string req);
    logic [7:0] st [16];
    bit sm [16];
    bit pend = 0;
    int ofs = start % 16, row = start / 16, bc = 0;
    for (int k = 0; k < 16; k++) sm[k] = 0;
    wc = w; txn_prot = prot; txn_start = 1; cyc(); txn_start = 0;
    addr_vld = 1; addr = 8'(start); cyc(); addr_vld = 0;
    for (int i = 0; i < n; i++) begin
      bit e = exp_ack(prot, w, lock_m, row);
      data_vld = 1; data = tx_data[i]; #1;
      chk(ack_ok == e, req, "data ack", int'(ack_ok), int'(e));
      if (e) begin
        if (prot) pend = 1;
        else begin st[ofs] = tx_data[i]; sm[ofs] = 1; end
      end
      cyc(); data_vld = 0;
      ofs = (ofs + 1) % 16;
    end
    if (commit) begin
      stop_ack = 1; cyc(); stop_ack = 0;
      while (busy && bc < 500) begin
        bc++;
        if (poke && bc == 1) begin
          txn_start = 1; data_vld = 1; #1;
          chk(ack_ok == 0, "R7", "ack while busy", int'(ack_ok), 0);
        end else begin
          txn_start = 0; data_vld = 0;
        end
        @(negedge clk);
      end
      txn_start = 0; data_vld = 0;
      chk(bc == WR, "R7", "busy length", bc, WR);
      if (prot) begin
        if (pend) lock_m = 1;
      end else
        for (int k = 0; k < 16; k++) if (sm[k]) ref_mem[row * 16 + k] = st[k];
    end else begin
      cyc(); cyc();
      chk(busy == 0, "R5", "busy without commit", int'(busy), 0);
    end
    wc = 0;
    mem_cmp(req);
  endtask

  task automatic fill(input int n, input int base);
    for (int i = 0; i < n; i++) tx_data[i] = 8'(base + 7 * i);
  endtask

  task automatic probe_ack(input int a, input bit exp, input string req);
    // open an array txn, present one byte, then abandon it without commit
    txn_prot = 0; txn_start = 1; cyc(); txn_start = 0;
    addr_vld = 1; addr = 8'(a); cyc(); addr_vld = 0;
    data_vld = 1; data = 8'hEE; #1;
    chk(ack_ok == exp, req, "lock probe ack", int'(ack_ok), int'(exp));
    cyc(); data_vld = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin ref_mem[i] = 0; dut_mem[i] = 0; end
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1", "busy after reset", int'(busy), 0);
    chk(mem_we == 0, "R1", "we after reset", int'(mem_we), 0);
    chk(ack_ok == 0, "R1", "ack with no txn", int'(ack_ok), 0);
    rst_n = 1; cyc();
    chk(busy == 0 && ack_ok == 0, "R1", "idle after release", int'(busy), 0);

    fill(3, 8'h11); run_txn(0, 8'h42, 3, 0, 1, 0, "R2");            // plain page write
    fill(5, 8'h20); run_txn(0, 8'h7C, 5, 0, 1, 0, "R3");            // wraps 7C..7F,70
    fill(18, 8'h51); run_txn(0, 8'h35, 18, 0, 1, 1, "R4");          // 18 bytes, busy poke
    stop_ack = 1; cyc(); stop_ack = 0; @(negedge clk);
    chk(busy == 0, "R7", "start during busy ignored", int'(busy), 0);
    fill(4, 8'h90); run_txn(0, 8'h60, 4, 0, 0, 0, "R5");            // no commit
    fill(2, 8'hA0); run_txn(0, 8'hC8, 2, 0, 1, 0, "R6");            // partial row
    fill(4, 8'hB3); run_txn(0, 8'h22, 4, 1, 1, 0, "R8");            // wc high
    fill(1, 8'h01); run_txn(1, 8'h00, 1, 1, 1, 0, "R8");            // lock blocked by wc
    probe_ack(8'h10, 1, "R8");
    fill(1, 8'h01); run_txn(1, 8'h00, 1, 0, 1, 0, "R9");            // set lock
    fill(3, 8'h66); run_txn(0, 8'h14, 3, 0, 1, 0, "R9");            // refused
    fill(3, 8'h77); run_txn(0, 8'h94, 3, 0, 1, 0, "R9");            // upper ok

    for (int t = 0; t < 40; t++) begin
      int n = 1 + int'($urandom % 20);
      bit p = (t > 20) && ($urandom % 8 == 0);
      fill(n, int'($urandom % 256));
      run_txn(p, int'($urandom % 256), n, ($urandom % 4) == 0, ($urandom % 4) != 0, 0, "R6");
    end
    probe_ack(8'h05, 0, "R10");
    rst_n = 0; cyc(); rst_n = 1; lock_m = 0; cyc();
    probe_ack(8'h05, 1, "R10");
    finish_run();
  end
endmodule